// File: doc/BRIEF.md
# Reset Exception Sequencer with Start-Address Fetch

This block decides when the processor core must stop and when it may start again. It takes an asynchronous active-low reset line from outside the chip and a one-cycle overflow pulse from the watchdog. The external line first passes through a synchronizer. A counter then measures how long the line stays low, so that a brief glitch cannot trigger a full restart. While a qualified reset or a watchdog reset is active, the core is held halted.

When the reset ends, the block runs a fixed restart sequence:
1. It pulses a clear signal to the supporting modules.
2. In the same cycle it pulses a request that sets the core's interrupt mask bit.
3. It reads the 32-bit start address as two 16-bit words over a simple request/ready memory port. The upper half comes from the vector base and the lower half from the base plus two.
4. It presents the assembled address together with a one-cycle start strobe, in the same cycle it lets the core run.

A new reset during the sequence sends the block back to the halted state, and the sequence starts over on release.

Top module: `rst_seq_top`

## Requirements
- R1: After `por_n` goes low and while it stays low, `core_halt` is 1, and `mem_req`, `start_stb`, `mod_clear` and `imask_set` are 0. After `por_n` rises with `ext_rst_n` high, the restart sequence runs once by itself.
- R2: A low pulse on `ext_rst_n` that lasts fewer than QUAL_CYC (default 10) clock cycles while the core runs has these properties:
  - It causes no memory read, no clear pulse and no start strobe.
  - `core_halt` returns to 0 after the pulse.
- R3: A low pulse of QUAL_CYC cycles or longer is qualified. No memory read occurs while the line stays low, and the restart sequence begins only after the line returns high.
- R4: Once the synchronized reset is low (two clock edges after `ext_rst_n` falls), `core_halt` is 1. This holds even for pulses that later turn out too short.
- R5: A `wdt_ovf` pulse sets `core_halt` on the next cycle. The block then keeps the core halted, with no memory read, for at least WDT_HOLD_CYC (default 10) cycles, and afterwards runs the restart sequence without any external pulse.
- R6: Each restart sequence pulses `mod_clear` and `imask_set` together for exactly one cycle, in the cycle just before the first memory read request.
- R7: The vector is read as two handshakes:
  - The first read uses address VEC_BASE (default 0x0000) and the second uses VEC_BASE+2 (0x0002).
  - Each handshake completes on a cycle where `mem_req` and `mem_rdy` are both 1.
  - `mem_req` and `mem_addr` hold steady while `mem_rdy` is 0.
- R8: After the second read, `start_stb` is 1 for exactly one cycle and `start_pc` equals {word at 0x0000, word at 0x0002}. In that same cycle `core_halt` is 0.
- R9: A qualified reset or a watchdog pulse that arrives during the sequence abandons the sequence. No start strobe comes from the abandoned sequence, and a complete new sequence runs after release.
- R10: One cycle after the synchronized reset is seen low, `mem_req` and `start_stb` are 0. Reset overrides every step of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset of the block itself, async active-low |
| ext_rst_n | input | 1 | External reset line, async active-low, needs qualification |
| wdt_ovf | input | 1 | Watchdog overflow pulse, one cycle, synchronous |
| mem_rdy | input | 1 | Memory read data valid / handshake complete |
| mem_rdata | input | 16 | Memory read data word |
| core_halt | output | 1 | Holds the core stopped while 1 |
| mod_clear | output | 1 | One-cycle clear pulse to supporting modules |
| imask_set | output | 1 | One-cycle request to set the interrupt mask bit |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Byte address of the word being read |
| start_pc | output | 32 | Assembled start address |
| start_stb | output | 1 | One-cycle start strobe, start_pc valid |

## Verification
The bench drives reset pulses of random length around the qualification threshold, with exact tests at 9 and 10 cycles. An off-by-one counter would either restart on a 9-cycle glitch or ignore a 10-cycle reset. Random vector words and random ready delays would expose a design that swaps the two halves, reads the wrong address or drops a stalled handshake. A watchdog pulse followed by a ten-cycle window would catch a design that restarts too early. A reset injected while a read stalls would catch a design that finishes the abandoned fetch and fires a stray start strobe, or skips the clear on the retry.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // States of the restart controller
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_HOLD     = 3'd1,
    ST_CLEAR    = 3'd2,
    ST_FETCH_HI = 3'd3,
    ST_FETCH_LO = 3'd4,
    ST_START    = 3'd5
  } seq_state_e;

endpackage

// File: rtl/rst_seq_sync.sv
// Multi-stage synchronizer for the external reset line; powers up "asserted".
module rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic async_n,
  output logic sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = async_n;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], async_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rst_seq_qual.sv
// Measures the length of a synchronized low period; flags the cycle on which
// it reaches QUAL_CYC. Counter saturates at the threshold.
module rst_seq_qual #(
  parameter int QUAL_CYC = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_low,
  output logic qual_evt
);

  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(QUAL_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!rst_low) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual_evt = rst_low && (cnt_q == CNT_LAST);

endmodule

// File: rtl/rst_seq_wdt_hold.sv
// Stretches a watchdog overflow pulse into a fixed internal reset window.
module rst_seq_wdt_hold #(
  parameter int HOLD_CYC = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic ovf,
  output logic busy
);

  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (ovf) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(HOLD_CYC);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/rst_seq_fsm.sv
// Restart controller: halt, clear, two-word vector fetch, start handoff.
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 16,
  parameter logic [15:0] VEC_BASE = 16'h0000
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_low,
  input  logic                qual_evt,
  input  logic                wdt_ovf,
  input  logic                wdt_busy,
  input  logic                mem_rdy,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                core_halt,
  output logic                mod_clear,
  output logic                imask_set,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*DATA_W-1:0] start_pc,
  output logic                start_stb
);

  localparam int              PC_W      = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] ADDR_HI = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] ADDR_LO = ADDR_W'(VEC_BASE) + ADDR_W'(DATA_W / 8);

  seq_state_e         st_q, st_d;
  logic               armed_q, armed_d;
  logic [DATA_W-1:0]  hi_q, hi_d;
  logic               hi_en;
  logic [PC_W-1:0]    pc_q, pc_d;
  logic               pc_en;
  logic               in_seq;
  logic               abort;
  logic               start_go;

  assign in_seq = (st_q == ST_CLEAR) || (st_q == ST_FETCH_HI) ||
                  (st_q == ST_FETCH_LO) || (st_q == ST_START);
  assign abort  = in_seq && (rst_low || wdt_ovf);

  // next-state process
  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    hi_en   = 1'b0;
    hi_d    = hi_q;
    pc_en   = 1'b0;
    pc_d    = pc_q;
    unique case (st_q)
      ST_RUN: begin
        if (qual_evt || wdt_ovf) begin
          st_d    = ST_HOLD;
          armed_d = 1'b1;
        end
      end
      ST_HOLD: begin
        if (wdt_ovf || qual_evt) begin
          armed_d = 1'b1;
        end else if (armed_q && !rst_low && !wdt_busy) begin
          st_d    = ST_CLEAR;
          armed_d = 1'b0;
        end
      end
      ST_CLEAR: st_d = ST_FETCH_HI;
      ST_FETCH_HI: begin
        if (mem_rdy) begin
          hi_en = 1'b1;
          hi_d  = mem_rdata;
          st_d  = ST_FETCH_LO;
        end
      end
      ST_FETCH_LO: begin
        if (mem_rdy) begin
          pc_en = 1'b1;
          pc_d  = {hi_q, mem_rdata};
          st_d  = ST_START;
        end
      end
      ST_START: st_d = ST_RUN;
      default:  st_d = ST_HOLD;
    endcase
    if (abort) begin
      st_d    = ST_HOLD;
      armed_d = 1'b1;
      hi_en   = 1'b0;
      pc_en   = 1'b0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q    <= ST_HOLD;
      armed_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  // outputs
  assign start_go  = (st_q == ST_START) && !rst_low && !wdt_ovf;
  assign start_stb = start_go;
  assign start_pc  = pc_q;
  assign core_halt = rst_low || ((st_q != ST_RUN) && !start_go);
  assign mod_clear = (st_q == ST_CLEAR);
  assign imask_set = (st_q == ST_CLEAR);
  assign mem_req   = (st_q == ST_FETCH_HI) || (st_q == ST_FETCH_LO);
  assign mem_addr  = (st_q == ST_FETCH_LO) ? ADDR_LO : ADDR_HI;

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int          QUAL_CYC     = 10,
  parameter int          WDT_HOLD_CYC = 10,
  parameter int          SYNC_STAGES  = 2,
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 16,
  parameter logic [15:0] VEC_BASE     = 16'h0000
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                ext_rst_n,
  input  logic                wdt_ovf,
  input  logic                mem_rdy,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                core_halt,
  output logic                mod_clear,
  output logic                imask_set,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*DATA_W-1:0] start_pc,
  output logic                start_stb
);

  logic ext_sync_n;
  logic rst_low;
  logic qual_evt;
  logic wdt_busy;

  rst_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .por_n   (por_n),
    .async_n (ext_rst_n),
    .sync_n  (ext_sync_n)
  );

  assign rst_low = ~ext_sync_n;

  rst_seq_qual #(.QUAL_CYC(QUAL_CYC)) qual_i (
    .clk      (clk),
    .por_n    (por_n),
    .rst_low  (rst_low),
    .qual_evt (qual_evt)
  );

  rst_seq_wdt_hold #(.HOLD_CYC(WDT_HOLD_CYC)) wdt_i (
    .clk   (clk),
    .por_n (por_n),
    .ovf   (wdt_ovf),
    .busy  (wdt_busy)
  );

  rst_seq_fsm #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .VEC_BASE (VEC_BASE)
  ) fsm_i (
    .clk       (clk),
    .por_n     (por_n),
    .rst_low   (rst_low),
    .qual_evt  (qual_evt),
    .wdt_ovf   (wdt_ovf),
    .wdt_busy  (wdt_busy),
    .mem_rdy   (mem_rdy),
    .mem_rdata (mem_rdata),
    .core_halt (core_halt),
    .mod_clear (mod_clear),
    .imask_set (imask_set),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .start_pc  (start_pc),
    .start_stb (start_stb)
  );

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_BASE = 16'h0000
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_low,
  input logic              wdt_ovf,
  input logic              core_halt,
  input logic              mod_clear,
  input logic              imask_set,
  input logic              mem_req,
  input logic              mem_rdy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              start_stb
);

  // R4: synchronized reset low always stops the core
  a_r4_halt_on_reset: assert property (@(posedge clk) disable iff (!por_n)
    rst_low |-> core_halt);

  // R5: watchdog pulse halts on the next cycle
  a_r5_wdt_halts: assert property (@(posedge clk) disable iff (!por_n)
    wdt_ovf |=> core_halt);

  // R6: first read request comes right after the clear / mask pulse
  a_r6_clear_before_fetch: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(mem_req) && mem_addr == ADDR_W'(VEC_BASE)) |-> ($past(mod_clear) && $past(imask_set)));

  // R6: clear pulse lasts one cycle
  a_r6_clear_single: assert property (@(posedge clk) disable iff (!por_n)
    mod_clear |=> !mod_clear);

  // R7: request and address held while waiting for ready
  a_r7_req_stable: assert property (@(posedge clk) disable iff (!por_n)
    (mem_req && !mem_rdy && !rst_low && !wdt_ovf) |=> (mem_req && $stable(mem_addr)));

  // R8: strobe lasts one cycle and releases the core
  a_r8_stb_single: assert property (@(posedge clk) disable iff (!por_n)
    start_stb |=> !start_stb);

  a_r8_stb_runs: assert property (@(posedge clk) disable iff (!por_n)
    start_stb |-> !core_halt);

  // R10: reset overrides the sequence
  a_r10_reset_quiets: assert property (@(posedge clk) disable iff (!por_n)
    rst_low |=> (!mem_req && !start_stb));

endmodule

bind rst_seq_top rst_seq_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) chk_i (
  .clk       (clk),
  .por_n     (por_n),
  .rst_low   (rst_low),
  .wdt_ovf   (wdt_ovf),
  .core_halt (core_halt),
  .mod_clear (mod_clear),
  .imask_set (imask_set),
  .mem_req   (mem_req),
  .mem_rdy   (mem_rdy),
  .mem_addr  (mem_addr),
  .start_stb (start_stb)
);

// File: tb/rst_seq_top_tb_top.sv
`timescale 1ns/1ps
module rst_seq_top_tb_top;

  localparam int QUAL = 10;
  localparam int WHLD = 10;

  logic        clk;
  logic        por_n;
  logic        ext_rst_n;
  logic        wdt_ovf;
  logic        mem_rdy;
  logic [15:0] mem_rdata;
  logic        core_halt;
  logic        mod_clear;
  logic        imask_set;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [31:0] start_pc;
  logic        start_stb;

  rst_seq_top dut_i (
    .clk       (clk),
    .por_n     (por_n),
    .ext_rst_n (ext_rst_n),
    .wdt_ovf   (wdt_ovf),
    .mem_rdy   (mem_rdy),
    .mem_rdata (mem_rdata),
    .core_halt (core_halt),
    .mod_clear (mod_clear),
    .imask_set (imask_set),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .start_pc  (start_pc),
    .start_stb (start_stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks;
  int errors;
  int stb_cnt;
  int clr_cnt;
  int msk_cnt;
  int req_cnt;
  int hs_cnt;
  int stall;
  int wait_cnt;
  logic [15:0] vec_hi;
  logic [15:0] vec_lo;
  logic [31:0] last_pc;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit expect_restart(input int len);
    return len >= QUAL;
  endfunction

  function automatic logic [31:0] expect_pc(input logic [15:0] h, input logic [15:0] l);
    return {h, l};
  endfunction

  // monitor + memory responder, all at the falling edge
  initial begin
    mem_rdy   = 1'b0;
    mem_rdata = '0;
    wait_cnt  = 0;
    forever begin
      @(negedge clk);
      if (por_n) begin
        if (start_stb) begin
          stb_cnt++;
          last_pc = start_pc;
        end
        if (mod_clear) clr_cnt++;
        if (imask_set) msk_cnt++;
        if (mem_req)   req_cnt++;
      end
      if (mem_req && stall == 0) begin
        if (wait_cnt == 0) begin
          mem_rdy   = 1'b1;
          mem_rdata = (mem_addr == 16'h0000) ? vec_hi : vec_lo;
          // R7: handshake addresses must alternate 0x0000, 0x0002
          check(mem_addr == ((hs_cnt % 2 == 0) ? 16'h0000 : 16'h0002), "R7", "read address",
                {16'h0, mem_addr}, (hs_cnt % 2 == 0) ? 32'h0 : 32'h2);
          hs_cnt++;
          wait_cnt = $urandom_range(0, 3);
        end else begin
          mem_rdy = 1'b0;
          wait_cnt--;
        end
      end else begin
        mem_rdy = 1'b0;
      end
    end
  end

  // step n rising edges, land 5 ns after the last one
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic pulse(input int len);
    ext_rst_n = 1'b0;
    cyc(len);
    ext_rst_n = 1'b1;
  endtask

  task automatic wait_start(input int limit, output bit found);
    int base;
    base  = stb_cnt;
    found = 1'b0;
    for (int i = 0; i < limit; i++) begin
      cyc(1);
      if (stb_cnt != base) begin
        found = 1'b1;
        break;
      end
    end
  endtask

  task automatic new_vector();
    vec_hi = 16'($urandom);
    vec_lo = 16'($urandom);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    bit found;
    int s0, c0, m0, r0, len;
    void'($urandom(32'h5eed_0042));
    checks = 0; errors = 0; stb_cnt = 0; clr_cnt = 0; msk_cnt = 0;
    req_cnt = 0; hs_cnt = 0; stall = 0;
    por_n = 1'b0; ext_rst_n = 1'b1; wdt_ovf = 1'b0;
    new_vector();
    cyc(3);
    // R1 reset state
    check(core_halt == 1'b1, "R1", "halt in por", {31'h0, core_halt}, 1);
    check(!mem_req && !start_stb && !mod_clear && !imask_set, "R1", "quiet in por",
          {28'h0, mem_req, start_stb, mod_clear, imask_set}, 0);
    por_n = 1'b1;
    wait_start(60, found);
    check(found, "R1", "restart after por", {31'h0, found}, 1);
    check(last_pc == expect_pc(vec_hi, vec_lo), "R8", "start address", last_pc, expect_pc(vec_hi, vec_lo));
    check(clr_cnt == 1 && msk_cnt == 1, "R6", "clear/mask pulses", clr_cnt, 1);
    cyc(2);
    check(core_halt == 1'b0, "R8", "core running", {31'h0, core_halt}, 0);
    check(stb_cnt == 1, "R8", "single strobe", stb_cnt, 1);

    // R2 / R4: nine-cycle glitch
    s0 = stb_cnt; c0 = clr_cnt; r0 = req_cnt;
    ext_rst_n = 1'b0;
    cyc(4);
    check(core_halt == 1'b1, "R4", "halt during low", {31'h0, core_halt}, 1);
    cyc(QUAL - 1 - 4);
    ext_rst_n = 1'b1;
    cyc(20);
    check(stb_cnt == s0 && clr_cnt == c0 && req_cnt == r0, "R2", "glitch ignored",
          stb_cnt - s0 + req_cnt - r0, 0);
    check(core_halt == 1'b0, "R2", "running after glitch", {31'h0, core_halt}, 0);

    // R3: exactly the threshold, and longer pulse
    for (int k = 0; k < 2; k++) begin
      new_vector();
      r0 = req_cnt;
      len = (k == 0) ? QUAL : QUAL + 15;
      pulse(len);
      check(req_cnt == r0, "R3", "no read while low", req_cnt - r0, 0);
      wait_start(60, found);
      check(found, "R3", "restart on release", {31'h0, found}, 1);
      check(last_pc == expect_pc(vec_hi, vec_lo), "R8", "start address", last_pc, expect_pc(vec_hi, vec_lo));
      cyc(3);
    end

    // R5: watchdog
    new_vector();
    r0 = req_cnt; s0 = stb_cnt;
    wdt_ovf = 1'b1;
    cyc(1);
    wdt_ovf = 1'b0;
    check(core_halt == 1'b1, "R5", "halt after wdt", {31'h0, core_halt}, 1);
    cyc(WHLD);
    check(req_cnt == r0 && core_halt == 1'b1, "R5", "hold window", req_cnt - r0, 0);
    wait_start(60, found);
    check(found && stb_cnt == s0 + 1, "R5", "restart after wdt", stb_cnt - s0, 1);
    check(last_pc == expect_pc(vec_hi, vec_lo), "R8", "start address", last_pc, expect_pc(vec_hi, vec_lo));
    cyc(3);

    // R9 / R10: reset during a stalled fetch
    new_vector();
    stall = 1;
    s0 = stb_cnt; c0 = clr_cnt;
    pulse(QUAL + 2);
    for (int i = 0; i < 30 && !mem_req; i++) cyc(1);
    check(mem_req == 1'b1, "R7", "fetch pending", {31'h0, mem_req}, 1);
    ext_rst_n = 1'b0;
    cyc(3);
    check(mem_req == 1'b0 && start_stb == 1'b0, "R10", "reset quiets fetch", {31'h0, mem_req}, 0);
    cyc(QUAL);
    stall = 0;
    new_vector();
    ext_rst_n = 1'b1;
    wait_start(60, found);
    cyc(5);
    check(stb_cnt == s0 + 1, "R9", "one strobe after abort", stb_cnt - s0, 1);
    check(clr_cnt == c0 + 2, "R9", "clear repeated", clr_cnt - c0, 2);
    check(last_pc == expect_pc(vec_hi, vec_lo), "R9", "retry address", last_pc, expect_pc(vec_hi, vec_lo));

    // random pulse lengths around the threshold
    for (int it = 0; it < 24; it++) begin
      new_vector();
      len = $urandom_range(3, 20);
      s0 = stb_cnt; r0 = req_cnt; m0 = msk_cnt;
      pulse(len);
      if (expect_restart(len)) begin
        wait_start(60, found);
        check(found, "R3", "random qualified restart", len, QUAL);
        check(last_pc == expect_pc(vec_hi, vec_lo), "R8", "random start address",
              last_pc, expect_pc(vec_hi, vec_lo));
        check(msk_cnt == m0 + 1, "R6", "mask pulse per restart", msk_cnt - m0, 1);
      end else begin
        cyc(25);
        check(stb_cnt == s0 && req_cnt == r0, "R2", "random glitch ignored", len, QUAL);
      end
      cyc($urandom_range(3, 8));
    end

    summary();
    $finish;
  end

endmodule